// File: doc/BRIEF.md
# Two-Wire Bus Connection Sequencer

This block decides when two segments of a two-wire serial bus (an upstream segment and a downstream segment, each with a data line and a clock line) may be joined through an external pass stage. It samples the logic levels of all four lines. It also takes an enable request, a supply-lockout flag, and fault and clear indications from a separate stuck-bus timer. From these it produces a connect command, a precharge enable, a rise-time accelerator enable, a ready flag, a recovery-clocking permit and a timer restart pulse.

After lockout ends, the segments are joined only when traffic on both has finished. Both segments must be quiet for a programmable number of clock cycles. The alternative is that one segment has just shown a stop condition while the other is quiet. Dropping the enable opens the link and withdraws ready. A new enable edge after a stuck-bus fault forces the link closed at once, whether or not the fault has cleared, and asks the timer to start over. Precharge is released at the first connection and is asserted again only by a new lockout.

Top module: `twb_link_seq`

## Requirements
- R1: While `uvlo_i` is high, line activity is ignored: `connect_o`, `ready_o` and `accel_en_o` stay low and `precharge_en_o` is high.
- R2: A segment counts as quiet once both of its lines have been sampled high for `IDLE_TICKS` consecutive cycles. With `enable_i` high and both segments quiet, `connect_o` rises.
- R3: A low on either line of a segment restarts that segment's quiet count from zero, so no connection on the quiet rule happens earlier than `IDLE_TICKS` cycles after the last low.
- R4: A stop condition on one segment (data rising while clock is high) connects the link within a few cycles, provided the other segment is quiet.
- R5: A stop condition on one segment does not connect the link while the other segment is not quiet.
- R6: `precharge_en_o` falls at the first connection. It stays low through enable changes and faults, and rises again only when `uvlo_i` is asserted.
- R7: With `enable_i` low, `ready_o` and `recov_en_o` are low in the same cycle, and `connect_o` is low from the next cycle on.
- R8: When `enable_i` returns high, the link waits for the quiet or stop rule again and does not connect at once.
- R9: A rising edge on `fault_i` while connected opens the link and drops `ready_o`. While the fault state holds and `enable_i` is high, `recov_en_o` is high.
- R10: A rising edge on `enable_i` in the fault state connects the link in the next cycle, even with `fault_i` still high, and gives a one-cycle pulse on `timer_restart_o`.
- R11: `clear_i` in the fault state returns the block to waiting, and it reconnects only under the quiet or stop rule.
- R12: `accel_en_o` is high only while connected and `recov_active_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_sda_i | input | 1 | Upstream data line level |
| up_scl_i | input | 1 | Upstream clock line level |
| dn_sda_i | input | 1 | Downstream data line level |
| dn_scl_i | input | 1 | Downstream clock line level |
| enable_i | input | 1 | Connection request |
| uvlo_i | input | 1 | Supply lockout active |
| fault_i | input | 1 | Stuck-bus fault from the timer block |
| clear_i | input | 1 | Stuck condition has cleared |
| recov_active_i | input | 1 | Recovery clocking is running |
| connect_o | output | 1 | Close the pass stage |
| precharge_en_o | output | 1 | Enable line precharge |
| accel_en_o | output | 1 | Enable rise-time accelerators |
| ready_o | output | 1 | Link is up and enabled |
| recov_en_o | output | 1 | Recovery clocking permitted |
| timer_restart_o | output | 1 | One-cycle request to restart the stuck timer |

## Verification
The assertions assume that `fault_i` is a level, so its rising edge marks one new fault. They also assume `enable_i`, `uvlo_i` and `clear_i` are synchronous to `clk`, and that the line inputs change no faster than the synchronizer can follow. The stimulus drives every input on the falling clock edge. It holds each line level for several cycles. It raises the fault once per fault episode and lowers it only after the restart pulse. It pulses the clear for exactly one cycle.

// File: rtl/twb_seq_pkg.sv
package twb_seq_pkg;
    typedef enum logic [1:0] {
        ST_LOCK  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CONN  = 2'd2,
        ST_FAULT = 2'd3
    } link_state_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } wire_pair_t;

    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_UP   = 0;
    localparam int unsigned SIDE_DN   = 1;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync
    import twb_seq_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  wire_pair_t line_i,
    output wire_pair_t line_o
);
    localparam int unsigned LAST = STAGES - 1;

    wire_pair_t chain_d [STAGES];
    wire_pair_t chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb chain_d[g] = line_i;
            end else begin : g_rest
                always_comb chain_d[g] = chain_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '{sda: 1'b1, scl: 1'b1};
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign line_o = chain_q[LAST];
endmodule

// File: rtl/twb_side_mon.sv
module twb_side_mon
    import twb_seq_pkg::*;
#(
    parameter int unsigned IDLE_TICKS = 11875
) (
    input  logic       clk,
    input  logic       rst_n,
    input  wire_pair_t line_i,
    output logic       idle_o,
    output logic       stop_o
);
    localparam int unsigned CNT_W = $clog2(IDLE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(IDLE_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        wire_pair_t       prev;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d      = mon_q;
        mon_d.prev = line_i;
        if (!(line_i.sda && line_i.scl))
            mon_d.cnt = '0;
        else if (mon_q.cnt != CNT_TOP)
            mon_d.cnt = mon_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '{cnt: '0, prev: '{sda: 1'b1, scl: 1'b1}};
        else        mon_q <= mon_d;
    end

    assign idle_o = (mon_q.cnt == CNT_TOP);
    assign stop_o = line_i.sda && !mon_q.prev.sda && line_i.scl && mon_q.prev.scl;

    // R3
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_i.sda || !line_i.scl) |=> !idle_o);
endmodule

// File: rtl/twb_link_fsm.sv
module twb_link_fsm
    import twb_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 uvlo_i,
    input  logic                 enable_i,
    input  logic                 fault_i,
    input  logic                 clear_i,
    input  logic                 recov_active_i,
    input  logic [NUM_SIDES-1:0] idle_i,
    input  logic [NUM_SIDES-1:0] stop_i,
    output logic                 connect_o,
    output logic                 precharge_o,
    output logic                 accel_o,
    output logic                 ready_o,
    output logic                 recov_en_o,
    output logic                 timer_restart_o
);
    typedef struct packed {
        link_state_e state;
        logic        precharge;
        logic        en_prev;
        logic        fault_prev;
        logic        restart;
    } fsm_t;

    fsm_t r_d, r_q;
    logic join_ok, en_rise, fault_rise;

    always_comb begin
        join_ok = (idle_i[SIDE_UP] && idle_i[SIDE_DN])
               || (stop_i[SIDE_UP] && idle_i[SIDE_DN])
               || (stop_i[SIDE_DN] && idle_i[SIDE_UP]);
        en_rise    = enable_i && !r_q.en_prev;
        fault_rise = fault_i && !r_q.fault_prev;

        r_d            = r_q;
        r_d.en_prev    = enable_i;
        r_d.fault_prev = fault_i;
        r_d.restart    = 1'b0;

        if (uvlo_i) begin
            r_d.state     = ST_LOCK;
            r_d.precharge = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_LOCK: r_d.state = ST_WAIT;
                ST_WAIT: begin
                    if (enable_i && join_ok) begin
                        r_d.state     = ST_CONN;
                        r_d.precharge = 1'b0;
                    end
                end
                ST_CONN: begin
                    if (!enable_i)       r_d.state = ST_WAIT;
                    else if (fault_rise) r_d.state = ST_FAULT;
                end
                ST_FAULT: begin
                    if (en_rise) begin
                        r_d.state     = ST_CONN;
                        r_d.precharge = 1'b0;
                        r_d.restart   = 1'b1;
                    end else if (clear_i) begin
                        r_d.state = ST_WAIT;
                    end
                end
                default: r_d.state = ST_LOCK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_LOCK, precharge: 1'b1, en_prev: 1'b0,
                             fault_prev: 1'b0, restart: 1'b0};
        else        r_q <= r_d;
    end

    assign connect_o       = (r_q.state == ST_CONN);
    assign ready_o         = (r_q.state == ST_CONN) && enable_i;
    assign accel_o         = (r_q.state == ST_CONN) && !recov_active_i;
    assign recov_en_o      = (r_q.state == ST_FAULT) && enable_i;
    assign precharge_o     = r_q.precharge;
    assign timer_restart_o = r_q.restart;

    // R1
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> (r_q.state == ST_LOCK && r_q.precharge));
    // R6
    precharge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo_i && !r_q.precharge) |=> !r_q.precharge);
    // R7
    enable_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !uvlo_i && r_q.state == ST_CONN) |=> r_q.state == ST_WAIT);
    // R9
    fault_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_i) && enable_i && !uvlo_i && r_q.state == ST_CONN)
        |=> r_q.state == ST_FAULT);
    // R10
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.restart |=> !r_q.restart);
    // R10
    restart_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.restart |-> (r_q.state == ST_CONN && !r_q.precharge));
endmodule

// File: rtl/twb_link_seq.sv
module twb_link_seq
    import twb_seq_pkg::*;
#(
    parameter int unsigned IDLE_TICKS  = 11875,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_sda_i,
    input  logic up_scl_i,
    input  logic dn_sda_i,
    input  logic dn_scl_i,
    input  logic enable_i,
    input  logic uvlo_i,
    input  logic fault_i,
    input  logic clear_i,
    input  logic recov_active_i,
    output logic connect_o,
    output logic precharge_en_o,
    output logic accel_en_o,
    output logic ready_o,
    output logic recov_en_o,
    output logic timer_restart_o
);
    wire_pair_t           raw_line  [NUM_SIDES];
    wire_pair_t           sync_line [NUM_SIDES];
    logic [NUM_SIDES-1:0] side_idle;
    logic [NUM_SIDES-1:0] side_stop;

    assign raw_line[SIDE_UP] = '{sda: up_sda_i, scl: up_scl_i};
    assign raw_line[SIDE_DN] = '{sda: dn_sda_i, scl: dn_scl_i};

    genvar s;
    generate
        for (s = 0; s < NUM_SIDES; s++) begin : g_side
            twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (raw_line[s]),
                .line_o (sync_line[s])
            );
            twb_side_mon #(.IDLE_TICKS(IDLE_TICKS)) u_mon (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_i (sync_line[s]),
                .idle_o (side_idle[s]),
                .stop_o (side_stop[s])
            );
        end
    endgenerate

    twb_link_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .uvlo_i          (uvlo_i),
        .enable_i        (enable_i),
        .fault_i         (fault_i),
        .clear_i         (clear_i),
        .recov_active_i  (recov_active_i),
        .idle_i          (side_idle),
        .stop_i          (side_stop),
        .connect_o       (connect_o),
        .precharge_o     (precharge_en_o),
        .accel_o         (accel_en_o),
        .ready_o         (ready_o),
        .recov_en_o      (recov_en_o),
        .timer_restart_o (timer_restart_o)
    );
endmodule

// File: tb/twb_link_seq_bench.sv
module twb_link_seq_bench;
    localparam int N = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_sda = 1'b1, up_scl = 1'b1, dn_sda = 1'b1, dn_scl = 1'b1;
    logic enable = 1'b0, uvlo = 1'b1, fault = 1'b0, clear = 1'b0, recov_active = 1'b0;
    logic connect, precharge, accel, ready, recov_en, restart;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    twb_link_seq #(.IDLE_TICKS(N)) u_twb_link_seq (
        .clk(clk), .rst_n(rst_n),
        .up_sda_i(up_sda), .up_scl_i(up_scl), .dn_sda_i(dn_sda), .dn_scl_i(dn_scl),
        .enable_i(enable), .uvlo_i(uvlo), .fault_i(fault), .clear_i(clear),
        .recov_active_i(recov_active),
        .connect_o(connect), .precharge_en_o(precharge), .accel_en_o(accel),
        .ready_o(ready), .recov_en_o(recov_en), .timer_restart_o(restart)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic t_reset_lock;
        tick(2);
        chk(connect, 1'b0, "R1 reset connect");
        chk(ready, 1'b0, "R1 reset ready");
        chk(precharge, 1'b1, "R1 reset precharge");
        chk(restart, 1'b0, "R10 reset restart");
        rst_n = 1'b1;
        enable = 1'b1;
        up_sda = 1'b0; tick(3); up_sda = 1'b1; tick(3 * N);
        chk(connect, 1'b0, "R1 lockout connect");
        chk(ready, 1'b0, "R1 lockout ready");
        chk(accel, 1'b0, "R1 lockout accel");
        chk(precharge, 1'b1, "R1 lockout precharge");
    endtask

    task automatic t_idle_join;
        up_scl = 1'b0; tick(4);
        up_scl = 1'b1; uvlo = 1'b0;
        tick(N - 3);
        chk(connect, 1'b0, "R3 early connect after low");
        tick(9);
        chk(connect, 1'b1, "R2 quiet connect");
        chk(ready, 1'b1, "R2 ready");
        chk(precharge, 1'b0, "R6 precharge off");
        chk(accel, 1'b1, "R12 accel on");
        recov_active = 1'b1; #1;
        chk(accel, 1'b0, "R12 accel held off");
        recov_active = 1'b0; #1;
    endtask

    task automatic t_enable_cycle;
        enable = 1'b0; #1;
        chk(ready, 1'b0, "R7 ready drop");
        tick(1);
        chk(connect, 1'b0, "R7 connect open");
        chk(recov_en, 1'b0, "R7 recov inhibited");
        dn_sda = 1'b0; tick(4);
        enable = 1'b1; tick(5);
        chk(connect, 1'b0, "R8 no immediate join");
        dn_sda = 1'b1; tick(1);
        chk(connect, 1'b0, "R4 not before stop seen");
        tick(3);
        chk(connect, 1'b1, "R4 stop join");
        chk(precharge, 1'b0, "R6 precharge stays off");
    endtask

    task automatic t_stop_busy;
        enable = 1'b0; tick(1);
        dn_scl = 1'b0; up_sda = 1'b0; tick(4);
        enable = 1'b1; tick(3);
        up_sda = 1'b1; tick(8);
        chk(connect, 1'b0, "R5 stop with busy side");
        dn_scl = 1'b1; tick(N + 6);
        chk(connect, 1'b1, "R5 later quiet join");
    endtask

    task automatic t_fault;
        fault = 1'b1; tick(1);
        chk(connect, 1'b0, "R9 fault open");
        chk(ready, 1'b0, "R9 fault ready");
        chk(recov_en, 1'b1, "R9 recov permitted");
        enable = 1'b0; #1;
        chk(recov_en, 1'b0, "R7 recov inhibited in fault");
        tick(2);
        enable = 1'b1; tick(1);
        chk(connect, 1'b1, "R10 forced join");
        chk(ready, 1'b1, "R10 forced ready");
        chk(restart, 1'b1, "R10 restart pulse");
        tick(1);
        chk(restart, 1'b0, "R10 restart single");
        chk(connect, 1'b1, "R10 stays joined");
        fault = 1'b0; tick(2);
    endtask

    task automatic t_clear;
        dn_scl = 1'b0; tick(4);
        fault = 1'b1; tick(1);
        chk(connect, 1'b0, "R11 fault open");
        clear = 1'b1; tick(1); clear = 1'b0; #1;
        chk(recov_en, 1'b0, "R11 left fault");
        tick(5);
        chk(connect, 1'b0, "R11 waits after clear");
        fault = 1'b0;
        dn_scl = 1'b1; tick(N + 6);
        chk(connect, 1'b1, "R11 rejoin on quiet");
    endtask

    task automatic t_relock;
        uvlo = 1'b1; tick(1);
        chk(precharge, 1'b1, "R6 precharge back on");
        chk(connect, 1'b0, "R1 relock open");
        uvlo = 1'b0; tick(1);
        chk(precharge, 1'b1, "R6 precharge until join");
        tick(3);
        chk(connect, 1'b1, "R2 rejoin after lockout");
        chk(precharge, 1'b0, "R6 precharge dropped");
    endtask

    initial begin
        t_reset_lock();
        t_idle_join();
        t_enable_cycle();
        t_stop_busy();
        t_fault();
        t_clear();
        t_relock();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule